// File: doc/BRIEF.md
# DMA Side Address Sequencer

This block generates the address stream for one side of a DMA channel, either the read side or the write side. A start strobe captures a base address. Each advance strobe then marks one completed transaction and moves the address on by the transfer width, in the selected direction. An optional gather/scatter pattern inserts an extra skip after every programmed number of transactions. This lets the channel, for example, pick the low 16-bit half out of a row of 32-bit registers.

A block is a programmed number of transactions. The sequencer flags the final transaction of each block. When a block ends, the side either returns to the captured base address (reload) or carries on from the address after the last one it used (contiguous). If neither this side nor the peer side reloads, the channel runs a single block: the sequencer raises a done flag and ignores further advance strobes until the next start. The configuration inputs must be held steady while a run is in progress.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is active and after it is released, `curAddr` is 0, and `done` and `lastInBlock` are low.
- R2: A `startStb` cycle loads `baseAddr` into `curAddr` on the next clock, clears `done`, restarts the transaction and gather counts, and begins a block.
- R3: In increment mode (`addrMode` = 0), each accepted advance adds the width in bytes: `widthCode` 0 adds 1, code 1 adds 2, and codes 2 and 3 add 4. The new address appears on the clock after the advance.
- R4: In decrement mode (`addrMode` = 1), each step subtracts the same byte amounts.
- R5: With `addrMode` 2 or 3 the address never changes, and the gather/scatter settings have no effect.
- R6: When `gsEnable` is high and `gsCount` is nonzero, every `gsCount`-th advance inside a block adds an extra `gsInterval` × width bytes in the stepping direction. The first skip therefore follows transaction number `gsCount`. Count 1, interval 1 at 16-bit width yields base, base+4, base+8, and so on.
- R7: `lastInBlock` is high exactly while the run is active and the current transaction is number `blockSize` of the block (`blockSize` ≥ 1).
- R8: With `reloadMode` high, the advance of the final transaction returns `curAddr` to the base captured at start.
- R9: With `reloadMode` low and `peerReload` high, the next block starts one plain width step past the last address, with no skip at the boundary, and the gather count starts again from zero.
- R10: With `reloadMode` and `peerReload` both low, the final advance sets `done`, which stays high until the next start. Advances while done leave `curAddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Begin a run from `baseAddr` |
| advStb | input | 1 | Current transaction completed |
| baseAddr | input | ADDR_W | Start address |
| widthCode | input | 2 | Transfer width: 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit |
| addrMode | input | 2 | 0 = increment, 1 = decrement, 2/3 = hold |
| gsEnable | input | 1 | Enable gather/scatter skipping |
| gsCount | input | GS_W | Transactions between skips (0 = no skip) |
| gsInterval | input | GS_W | Skip length in width units |
| blockSize | input | BLK_W | Transactions per block |
| reloadMode | input | 1 | This side reloads its base at each block end |
| peerReload | input | 1 | The other side of the channel reloads |
| curAddr | output | ADDR_W | Address of the current transaction |
| lastInBlock | output | 1 | Current transaction ends the block |
| done | output | 1 | Single-block run has finished |

## Verification
The bench builds the block with ADDR_W = 32, BLK_W = 9 and GS_W = 4. A 9-bit block field reaches a 256-transaction block, so the flag on the final transaction is checked at the far end of a long count and not only in short blocks. A 4-bit gather field keeps skip counts and intervals small enough that patterns such as a skip every second or third transaction, a multi-unit interval, and a gather count that restarts across a contiguous boundary all fall inside blocks of a handful of transactions. Every width code and every direction is run against addresses that the bench computes from a closed formula.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    MODE_INC   = 2'd0,
    MODE_DEC   = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_HOLDX = 2'd3
  } step_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchBase;  // capture external base and load it
    logic loadBase;   // return to captured base
    logic stepPlain;  // move by one width
    logic stepSkip;   // move by one width plus gather interval
  } addr_cmd_t;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int GS_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             advStb,
  input  logic [1:0]       addrMode,
  input  logic             gsEnable,
  input  logic [GS_W-1:0]  gsCount,
  input  logic [BLK_W-1:0] blockSize,
  input  logic             reloadMode,
  input  logic             peerReload,
  output addr_cmd_t        cmd,
  output logic             lastInBlock,
  output logic             done,
  output logic             active
);

  logic [BLK_W-1:0] xferCnt;
  logic [GS_W-1:0]  gsCnt;
  logic             moving;
  logic             gsOn;
  logic             gsWrap;
  logic             isLast;
  logic             step;

  assign moving = (step_mode_e'(addrMode) == MODE_INC) ||
                  (step_mode_e'(addrMode) == MODE_DEC);
  assign gsOn   = gsEnable && moving && (gsCount != '0);
  assign gsWrap = gsOn && (gsCnt == gsCount - GS_W'(1));
  assign isLast = active && (xferCnt == blockSize - BLK_W'(1));
  assign step   = advStb && active && !startStb;

  assign lastInBlock = isLast;

  always_comb begin
    cmd = '0;
    if (startStb) begin
      cmd.latchBase = 1'b1;
    end else if (step) begin
      if (isLast) begin
        if (reloadMode) cmd.loadBase  = 1'b1;
        else            cmd.stepPlain = 1'b1;
      end else if (gsWrap) begin
        cmd.stepSkip = 1'b1;
      end else begin
        cmd.stepPlain = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferCnt <= '0;
      gsCnt   <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
    end else if (startStb) begin
      xferCnt <= '0;
      gsCnt   <= '0;
      active  <= 1'b1;
      done    <= 1'b0;
    end else if (step) begin
      if (isLast) begin
        xferCnt <= '0;
        gsCnt   <= '0;
        if (!reloadMode && !peerReload) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else begin
        xferCnt <= xferCnt + BLK_W'(1);
        if (gsOn) gsCnt <= gsWrap ? '0 : gsCnt + GS_W'(1);
      end
    end
  end

endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GS_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  addr_cmd_t         cmd,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        widthCode,
  input  logic [1:0]        addrMode,
  input  logic [GS_W-1:0]   gsInterval,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int SHIFT_W = 2;

  logic [ADDR_W-1:0]  baseReg;
  logic [SHIFT_W-1:0] widthShift;
  logic [ADDR_W-1:0]  stepBytes;
  logic [ADDR_W-1:0]  skipBytes;
  logic [ADDR_W-1:0]  delta;
  logic [ADDR_W-1:0]  nextAddr;

  always_comb begin
    unique case (widthCode)
      2'd0:    widthShift = SHIFT_W'(0);
      2'd1:    widthShift = SHIFT_W'(1);
      default: widthShift = SHIFT_W'(2);
    endcase
  end

  assign stepBytes = ADDR_W'(1) << widthShift;
  assign skipBytes = ADDR_W'(gsInterval) << widthShift;
  assign delta     = cmd.stepSkip ? (stepBytes + skipBytes) : stepBytes;

  always_comb begin
    case (step_mode_e'(addrMode))
      MODE_INC: nextAddr = curAddr + delta;
      MODE_DEC: nextAddr = curAddr - delta;
      default:  nextAddr = curAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      baseReg <= '0;
    end else if (cmd.latchBase) begin
      curAddr <= baseAddr;
      baseReg <= baseAddr;
    end else if (cmd.loadBase) begin
      curAddr <= baseReg;
    end else if (cmd.stepPlain || cmd.stepSkip) begin
      curAddr <= nextAddr;
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 12,
  parameter int GS_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              advStb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        widthCode,
  input  logic [1:0]        addrMode,
  input  logic              gsEnable,
  input  logic [GS_W-1:0]   gsCount,
  input  logic [GS_W-1:0]   gsInterval,
  input  logic [BLK_W-1:0]  blockSize,
  input  logic              reloadMode,
  input  logic              peerReload,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastInBlock,
  output logic              done
);

  addr_cmd_t cmd;
  logic      runActive;

  dag_ctrl #(.BLK_W(BLK_W), .GS_W(GS_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .advStb     (advStb),
    .addrMode   (addrMode),
    .gsEnable   (gsEnable),
    .gsCount    (gsCount),
    .blockSize  (blockSize),
    .reloadMode (reloadMode),
    .peerReload (peerReload),
    .cmd        (cmd),
    .lastInBlock(lastInBlock),
    .done       (done),
    .active     (runActive)
  );

  dag_datapath #(.ADDR_W(ADDR_W), .GS_W(GS_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .baseAddr  (baseAddr),
    .widthCode (widthCode),
    .addrMode  (addrMode),
    .gsInterval(gsInterval),
    .curAddr   (curAddr)
  );

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic              advStb,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [1:0]        widthCode,
  input logic [1:0]        addrMode,
  input logic              gsEnable,
  input logic              reloadMode,
  input logic              peerReload,
  input logic [ADDR_W-1:0] curAddr,
  input logic              lastInBlock,
  input logic              done,
  input logic              runActive
);

  logic [ADDR_W-1:0] startBase;
  logic              accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         startBase <= '0;
    else if (startStb) startBase <= baseAddr;
  end

  assign accept = runActive && advStb && !startStb;

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (curAddr == $past(baseAddr)) && !done);

  a_r3_half_step: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !lastInBlock && addrMode == 2'd0 && !gsEnable && widthCode == 2'd1)
      |=> curAddr == $past(curAddr) + ADDR_W'(2));

  a_r5_hold_mode: assert property (@(posedge clk) disable iff (!rstN)
    (accept && addrMode[1]) |=> $stable(curAddr));

  a_r7_idle_no_last: assert property (@(posedge clk) disable iff (!rstN)
    !runActive |-> !lastInBlock);

  a_r8_reload_base: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastInBlock && reloadMode) |=> curAddr == startBase);

  a_r10_single_done: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastInBlock && !reloadMode && !peerReload) |=> done && !runActive);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startStb) |=> done && $stable(curAddr));

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startStb   (startStb),
  .advStb     (advStb),
  .baseAddr   (baseAddr),
  .widthCode  (widthCode),
  .addrMode   (addrMode),
  .gsEnable   (gsEnable),
  .reloadMode (reloadMode),
  .peerReload (peerReload),
  .curAddr    (curAddr),
  .lastInBlock(lastInBlock),
  .done       (done),
  .runActive  (runActive)
);

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;

  localparam int ADDR_W = 32;
  localparam int BLK_W  = 9;
  localparam int GS_W   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startStb = 1'b0;
  logic              advStb = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [1:0]        widthCode = '0;
  logic [1:0]        addrMode = '0;
  logic              gsEnable = 1'b0;
  logic [GS_W-1:0]   gsCount = '0;
  logic [GS_W-1:0]   gsInterval = '0;
  logic [BLK_W-1:0]  blockSize = BLK_W'(1);
  logic              reloadMode = 1'b0;
  logic              peerReload = 1'b0;
  logic [ADDR_W-1:0] curAddr;
  logic              lastInBlock;
  logic              done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_addr_gen #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .GS_W(GS_W)) dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .advStb(advStb),
    .baseAddr(baseAddr), .widthCode(widthCode), .addrMode(addrMode),
    .gsEnable(gsEnable), .gsCount(gsCount), .gsInterval(gsInterval),
    .blockSize(blockSize), .reloadMode(reloadMode), .peerReload(peerReload),
    .curAddr(curAddr), .lastInBlock(lastInBlock), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wBytes(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  // closed-form expected address of transaction k within a block
  function automatic logic [31:0] expAddr(input logic [31:0] base, input int k);
    int wb  = wBytes(int'(widthCode));
    int off = k * wb;
    if (gsEnable && gsCount != 0) off += (k / int'(gsCount)) * int'(gsInterval) * wb;
    if (addrMode == 2'd0) return base + off;
    if (addrMode == 2'd1) return base - off;
    return base;
  endfunction

  task automatic cfg(input int w, input int mode, input bit gse, input int cnt,
                     input int intv, input int bs, input bit rl, input bit prl);
    widthCode  = 2'(w);
    addrMode   = 2'(mode);
    gsEnable   = gse;
    gsCount    = GS_W'(cnt);
    gsInterval = GS_W'(intv);
    blockSize  = BLK_W'(bs);
    reloadMode = rl;
    peerReload = prl;
  endtask

  task automatic start(input logic [31:0] base);
    baseAddr = base;
    startStb = 1'b1;
    @(posedge clk); #1;
    startStb = 1'b0;
  endtask

  task automatic adv();
    advStb = 1'b1;
    @(posedge clk); #1;
    advStb = 1'b0;
  endtask

  task automatic runBlock(input string req, input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, curAddr, expAddr(base, k));
      chk("R7 lastInBlock", {31'b0, lastInBlock}, {31'b0, (k == n - 1)});
      adv();
    end
  endtask

  task automatic t_reset();
    chk("R1 addr in reset", curAddr, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 addr", curAddr, 32'h0);
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 last", {31'b0, lastInBlock}, 32'h0);
  endtask

  task automatic t_widths();
    for (int w = 0; w < 4; w++) begin
      cfg(w, 0, 1'b0, 0, 0, 8, 1'b1, 1'b0);
      start(32'h1000);
      chk("R2 start", curAddr, 32'h1000);
      runBlock("R3 inc width", 32'h1000, 8);
      chk("R8 reload", curAddr, 32'h1000);
    end
  endtask

  task automatic t_dec_contig();
    logic [31:0] nb;
    cfg(2, 1, 1'b0, 0, 0, 4, 1'b0, 1'b1);
    start(32'h2000);
    runBlock("R4 dec", 32'h2000, 4);
    nb = 32'h2000 - 32'd16;
    chk("R9 contiguous dec", curAddr, nb);
    runBlock("R4 dec blk2", nb, 4);
    chk("R9 no done", {31'b0, done}, 32'h0);
  endtask

  task automatic t_hold();
    cfg(1, 2, 1'b1, 1, 3, 5, 1'b0, 1'b1);
    start(32'h3000);
    runBlock("R5 hold", 32'h3000, 5);
    chk("R5 hold after block", curAddr, 32'h3000);
    cfg(1, 3, 1'b1, 2, 5, 3, 1'b1, 1'b0);
    start(32'h3100);
    runBlock("R5 hold code3", 32'h3100, 3);
  endtask

  task automatic t_gather();
    logic [31:0] nb;
    cfg(1, 0, 1'b1, 1, 1, 8, 1'b1, 1'b0);
    start(32'h4000);
    for (int k = 0; k < 8; k++) begin
      chk("R6 low halves", curAddr, 32'h4000 + 32'(4 * k));
      adv();
    end
    chk("R8 reload gather", curAddr, 32'h4000);
    cfg(0, 0, 1'b1, 2, 3, 5, 1'b0, 1'b1);
    start(32'h5000);
    runBlock("R6 count2 int3", 32'h5000, 5);
    nb = 32'h500B;
    chk("R9 contiguous no skip", curAddr, nb);
    runBlock("R6 gather restart", nb, 5);
    cfg(1, 1, 1'b1, 3, 2, 6, 1'b1, 1'b0);
    start(32'h6000);
    runBlock("R6 dec gather", 32'h6000, 6);
    chk("R8 reload dec", curAddr, 32'h6000);
  endtask

  task automatic t_single();
    cfg(2, 0, 1'b0, 0, 0, 3, 1'b0, 1'b0);
    start(32'h7000);
    runBlock("R3 single", 32'h7000, 3);
    chk("R10 done set", {31'b0, done}, 32'h1);
    chk("R10 end addr", curAddr, 32'h700C);
    adv();
    adv();
    chk("R10 adv ignored", curAddr, 32'h700C);
    chk("R10 done sticky", {31'b0, done}, 32'h1);
    chk("R10 no last", {31'b0, lastInBlock}, 32'h0);
    start(32'h7100);
    chk("R2 done cleared", {31'b0, done}, 32'h0);
    chk("R2 reload base", curAddr, 32'h7100);
    runBlock("R3 single again", 32'h7100, 3);
    chk("R10 done again", {31'b0, done}, 32'h1);
  endtask

  task automatic t_big();
    cfg(2, 0, 1'b0, 0, 0, 256, 1'b1, 1'b0);
    start(32'h8000);
    runBlock("R3 long block", 32'h8000, 256);
    chk("R8 long reload", curAddr, 32'h8000);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_widths();
    t_dec_contig();
    t_hold();
    t_gather();
    t_single();
    t_big();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule